// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller keep running while the core sleeps. When the core raises a sleep request, the controller reads a 3-bit mode code. It then switches off the CPU, flash and I/O clocks and the fast oscillator according to a fixed policy for that mode. Interrupt wake events bring the core back. Leaving the deepest mode follows an ordered sequence: the fast oscillator is enabled first, and the CPU clock returns only after the oscillator has reported ready for a programmable number of slow-clock ticks.

Two side enables are produced alongside the gates. The slow oscillator enable stays high through sleep only when the coulomb counter is in use. The charger-detection enable is granted only while the discharge FET is off. The oscillators and peripherals are outside the block; they appear only as enable outputs and status inputs. The slow clock enters as a one-cycle tick strobe in the system clock domain.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, all four clock enables (cpuClkEn, flashClkEn, ioClkEn, fastOscEn) are high and modeStatus is 2'b00 (running).
- R2: A sleep request with modeSel 3'b000 enters the light mode: CPU and flash clocks off, I/O clock and fast oscillator on, modeStatus 2'b01.
- R3: A sleep request with modeSel 3'b001 enters the quiet-conversion mode: CPU, flash and I/O clocks off, fast oscillator on, modeStatus 2'b10.
- R4: A sleep request with modeSel 3'b011 enters the deep mode: CPU, flash and I/O clocks and the fast oscillator all off, modeStatus 2'b11.
- R5: A sleep request with modeSel 3'b010 or any code with bit 2 set is ignored; the core stays running with all clocks on.
- R6: A wakeIrq high in the same cycle as a sleep request cancels the entry, and no clock is gated.
- R7: In the light or quiet-conversion mode, either wakeIrq or vregWarnIrq returns the controller to running with all clocks on.
- R8: In the deep mode, vregWarnIrq has no effect; only wakeIrq starts the wake sequence.
- R9: On wake from the deep mode, the fast oscillator is enabled first. The CPU clock stays off until fastOscReady has been high for readyCycles slowTick pulses, and it is released on the cycle after that count is reached. A low fastOscReady restarts the count. While waiting, modeStatus stays 2'b11.
- R10: slowOscEn is high while running; while asleep it equals ccEnable.
- R11: chargerDetEn is high only when chargerDetReq is high and dischargeFetOn is low.
- R12: The clock enables change only on the falling edge of clk: a mode change is visible on modeStatus after the rising edge, and the gates follow half a cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | One-cycle sleep request from the core |
| modeSel | input | 3 | Sleep mode code |
| wakeIrq | input | 1 | Combined external and internal interrupt wake event |
| vregWarnIrq | input | 1 | Regulator monitor warning interrupt |
| slowTick | input | 1 | One-cycle strobe for each slow-clock period |
| fastOscReady | input | 1 | Fast oscillator ready status |
| readyCycles | input | CNT_W | Required slow ticks of ready before the CPU clock is released |
| ccEnable | input | 1 | Coulomb counter in use |
| dischargeFetOn | input | 1 | Discharge FET currently on |
| chargerDetReq | input | 1 | Request to enable charger detection |
| cpuClkEn | output | 1 | CPU clock gate enable |
| flashClkEn | output | 1 | Flash clock gate enable |
| ioClkEn | output | 1 | I/O clock gate enable |
| fastOscEn | output | 1 | Fast oscillator enable |
| slowOscEn | output | 1 | Slow oscillator enable |
| chargerDetEn | output | 1 | Charger detection enable |
| modeStatus | output | 2 | Current mode: 00 running, 01 light, 10 quiet-conversion, 11 deep |

## Verification
A wrong internal state shows up on modeStatus right after the next rising edge, and on the four gate enables half a cycle later. This makes a mismatch between the mode code and the gating pattern visible within one cycle of the request. A faulty ready counter only becomes visible at the end of the wake sequence, as a CPU clock that returns too early, too late or never. For that reason the bench counts slow ticks itself and checks the CPU gate on both sides of the release cycle. It also checks the case where the ready signal drops part way through the count.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_LIGHT,
    ST_QUIET,
    ST_DEEP,
    ST_OSCWAIT
  } sleepState_e;

  // Strobes from control to gating datapath
  typedef struct packed {
    logic cpuOn;
    logic flashOn;
    logic ioOn;
    logic fastOn;
    logic asleep;
  } gateStrobe_t;

  localparam logic [2:0] MODE_LIGHT = 3'b000;
  localparam logic [2:0] MODE_QUIET = 3'b001;
  localparam logic [2:0] MODE_DEEP  = 3'b011;
endpackage

// File: rtl/sleep_clk_fsm.sv
module sleep_clk_fsm
  import sleep_clk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleepReq,
  input  logic [2:0]       modeSel,
  input  logic             wakeIrq,
  input  logic             vregWarnIrq,
  input  logic             slowTick,
  input  logic             fastOscReady,
  input  logic [CNT_W-1:0] readyCycles,
  output gateStrobe_t      strobe,
  output logic [1:0]       modeStatus
);
  sleepState_e state, stateNext;
  logic [CNT_W-1:0] readyCnt;
  logic readyDone;

  assign readyDone = fastOscReady && (readyCnt >= readyCycles);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (sleepReq && !wakeIrq) begin
          case (modeSel)
            MODE_LIGHT: stateNext = ST_LIGHT;
            MODE_QUIET: stateNext = ST_QUIET;
            MODE_DEEP:  stateNext = ST_DEEP;
            default:    stateNext = ST_RUN;
          endcase
        end
      end
      ST_LIGHT, ST_QUIET: if (wakeIrq || vregWarnIrq) stateNext = ST_RUN;
      ST_DEEP:            if (wakeIrq) stateNext = ST_OSCWAIT;
      ST_OSCWAIT:         if (readyDone) stateNext = ST_RUN;
      default:            stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      readyCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_OSCWAIT || !fastOscReady) readyCnt <= '0;
      else if (slowTick && readyCnt < readyCycles) readyCnt <= readyCnt + 1'b1;
    end
  end

  always_comb begin
    strobe     = '{cpuOn: 1'b1, flashOn: 1'b1, ioOn: 1'b1, fastOn: 1'b1, asleep: 1'b0};
    modeStatus = 2'b00;
    unique case (state)
      ST_LIGHT: begin
        strobe.cpuOn = 1'b0; strobe.flashOn = 1'b0; strobe.asleep = 1'b1;
        modeStatus = 2'b01;
      end
      ST_QUIET: begin
        strobe.cpuOn = 1'b0; strobe.flashOn = 1'b0; strobe.ioOn = 1'b0;
        strobe.asleep = 1'b1;
        modeStatus = 2'b10;
      end
      ST_DEEP: begin
        strobe = '{cpuOn: 1'b0, flashOn: 1'b0, ioOn: 1'b0, fastOn: 1'b0, asleep: 1'b1};
        modeStatus = 2'b11;
      end
      ST_OSCWAIT: begin
        strobe = '{cpuOn: 1'b0, flashOn: 1'b0, ioOn: 1'b0, fastOn: 1'b1, asleep: 1'b1};
        modeStatus = 2'b11;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sleep_clk_gates.sv
module sleep_clk_gates
  import sleep_clk_pkg::*;
#(
  parameter int N_GATES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  gateStrobe_t strobe,
  input  logic        ccEnable,
  input  logic        dischargeFetOn,
  input  logic        chargerDetReq,
  output logic        cpuClkEn,
  output logic        flashClkEn,
  output logic        ioClkEn,
  output logic        fastOscEn,
  output logic        slowOscEn,
  output logic        chargerDetEn
);
  logic [N_GATES-1:0] gateWant;
  logic [N_GATES-1:0] gateReg;

  assign gateWant = {strobe.cpuOn, strobe.flashOn, strobe.ioOn, strobe.fastOn};

  // Each enable retimed on the falling edge so it settles while the clock is low
  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gateReg[g] <= 1'b1;
      else        gateReg[g] <= gateWant[g];
    end
  end

  assign {cpuClkEn, flashClkEn, ioClkEn, fastOscEn} = gateReg;
  assign slowOscEn    = !strobe.asleep || ccEnable;
  assign chargerDetEn = chargerDetReq && !dischargeFetOn;
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_clk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleepReq,
  input  logic [2:0]       modeSel,
  input  logic             wakeIrq,
  input  logic             vregWarnIrq,
  input  logic             slowTick,
  input  logic             fastOscReady,
  input  logic [CNT_W-1:0] readyCycles,
  input  logic             ccEnable,
  input  logic             dischargeFetOn,
  input  logic             chargerDetReq,
  output logic             cpuClkEn,
  output logic             flashClkEn,
  output logic             ioClkEn,
  output logic             fastOscEn,
  output logic             slowOscEn,
  output logic             chargerDetEn,
  output logic [1:0]       modeStatus
);
  gateStrobe_t strobe;

  sleep_clk_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .modeSel(modeSel),
    .wakeIrq(wakeIrq), .vregWarnIrq(vregWarnIrq), .slowTick(slowTick),
    .fastOscReady(fastOscReady), .readyCycles(readyCycles),
    .strobe(strobe), .modeStatus(modeStatus)
  );

  sleep_clk_gates #(.N_GATES(4)) u_gates (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ccEnable(ccEnable),
    .dischargeFetOn(dischargeFetOn), .chargerDetReq(chargerDetReq),
    .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .ioClkEn(ioClkEn),
    .fastOscEn(fastOscEn), .slowOscEn(slowOscEn), .chargerDetEn(chargerDetEn)
  );
endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleepReq,
  input logic [2:0] modeSel,
  input logic       wakeIrq,
  input logic       vregWarnIrq,
  input logic       ccEnable,
  input logic       dischargeFetOn,
  input logic       cpuClkEn,
  input logic       ioClkEn,
  input logic       fastOscEn,
  input logic       slowOscEn,
  input logic       chargerDetEn,
  input logic [1:0] modeStatus
);
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus == 2'b00 && sleepReq && wakeIrq) |=> modeStatus == 2'b00);

  p_unused_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus == 2'b00 && sleepReq && (modeSel == 3'b010 || modeSel[2])) |=> modeStatus == 2'b00);

  p_deep_ignores_vreg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus == 2'b11 && vregWarnIrq && !wakeIrq) |=> modeStatus == 2'b11);

  p_cpu_needs_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpuClkEn |-> fastOscEn);

  p_light_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus == 2'b01 && $past(modeStatus) == 2'b01) |-> (ioClkEn && !cpuClkEn));

  p_slow_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus != 2'b00 && !ccEnable) |-> !slowOscEn);

  p_charger_fet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chargerDetEn |-> !dischargeFetOn);
endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (.*);

// File: tb/sleep_clk_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 0, wakeIrq = 0, vregWarnIrq = 0, slowTick = 0, fastOscReady = 0;
  logic [2:0] modeSel = '0;
  logic [CNT_W-1:0] readyCycles = '0;
  logic ccEnable = 0, dischargeFetOn = 0, chargerDetReq = 0;
  logic cpuClkEn, flashClkEn, ioClkEn, fastOscEn, slowOscEn, chargerDetEn;
  logic [1:0] modeStatus;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sleep_clk_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .modeSel(modeSel),
    .wakeIrq(wakeIrq), .vregWarnIrq(vregWarnIrq), .slowTick(slowTick),
    .fastOscReady(fastOscReady), .readyCycles(readyCycles),
    .ccEnable(ccEnable), .dischargeFetOn(dischargeFetOn), .chargerDetReq(chargerDetReq),
    .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .ioClkEn(ioClkEn),
    .fastOscEn(fastOscEn), .slowOscEn(slowOscEn), .chargerDetEn(chargerDetEn),
    .modeStatus(modeStatus)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // {cpu,flash,io,fast} expected for a status code
  function automatic logic [3:0] expGates(input logic [1:0] st);
    case (st)
      2'b00:   return 4'b1111;
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [1:0] expStatus(input logic [2:0] code);
    case (code)
      3'b000:  return 2'b01;
      3'b001:  return 2'b10;
      3'b011:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] gates();
    return {cpuClkEn, flashClkEn, ioClkEn, fastOscEn};
  endfunction

  // advance one rising edge, land after the following falling edge
  task automatic cyc();
    @(posedge clk); #6;
  endtask

  task automatic checkState(input string req, input logic [1:0] st);
    chk(req, {6'd0, modeStatus}, {6'd0, st});
    chk(req, {4'd0, gates()}, {4'd0, expGates(st)});
  endtask

  task automatic enter(input logic [2:0] code, input logic cancel);
    modeSel = code; sleepReq = 1; wakeIrq = cancel;
    cyc();
    sleepReq = 0; wakeIrq = 0;
  endtask

  task automatic sideChecks(input string tag);
    ccEnable = 1'($urandom); dischargeFetOn = 1'($urandom); chargerDetReq = 1'($urandom);
    #1;
    chk({tag, " R10"}, {7'd0, slowOscEn}, {7'd0, (modeStatus == 2'b00) || ccEnable});
    chk({tag, " R11"}, {7'd0, chargerDetEn}, {7'd0, chargerDetReq && !dischargeFetOn});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    checkState("R1", 2'b00);

    // R12: status after rising edge, gates after falling edge
    modeSel = 3'b000; sleepReq = 1;
    @(posedge clk); #1; sleepReq = 0;
    chk("R12 status", {6'd0, modeStatus}, 8'h01);
    chk("R12 cpu held", {7'd0, cpuClkEn}, 8'h01);
    #5;
    checkState("R2", 2'b01);
    sideChecks("light");
    vregWarnIrq = 1; cyc(); vregWarnIrq = 0;
    checkState("R7 vreg wake", 2'b00);

    // R3 and R7 via interrupt
    enter(3'b001, 0);
    checkState("R3", 2'b10);
    sideChecks("quiet");
    wakeIrq = 1; cyc(); wakeIrq = 0;
    checkState("R7 irq wake", 2'b00);

    // R6 cancellation
    enter(3'b011, 1);
    checkState("R6", 2'b00);

    // R5 unused codes
    enter(3'b010, 0);
    checkState("R5 010", 2'b00);
    enter(3'b110, 0);
    checkState("R5 110", 2'b00);

    // R4, R8, R9 directed wake sequence
    readyCycles = 8'd3; fastOscReady = 0;
    enter(3'b011, 0);
    checkState("R4", 2'b11);
    sideChecks("deep");
    vregWarnIrq = 1; cyc(); vregWarnIrq = 0;
    checkState("R8", 2'b11);
    wakeIrq = 1; cyc(); wakeIrq = 0;
    chk("R9 fast first", {4'd0, gates()}, 8'h01);
    chk("R9 status", {6'd0, modeStatus}, 8'h03);
    cyc(); cyc();
    chk("R9 no ready", {7'd0, cpuClkEn}, 8'h00);
    fastOscReady = 1;
    for (int i = 0; i < 2; i++) begin slowTick = 1; cyc(); slowTick = 0; cyc(); end
    fastOscReady = 0; cyc(); fastOscReady = 1;
    for (int i = 0; i < 2; i++) begin slowTick = 1; cyc(); slowTick = 0; end
    chk("R9 restart count", {7'd0, cpuClkEn}, 8'h00);
    slowTick = 1; cyc(); slowTick = 0;
    chk("R9 before release", {7'd0, cpuClkEn}, 8'h00);
    cyc();
    checkState("R9 released", 2'b00);

    // random mix
    readyCycles = 8'd0;
    for (int n = 0; n < 40; n++) begin
      logic [2:0] code;
      logic cancel, useVreg;
      code = 3'($urandom);
      cancel = ($urandom % 5) == 0;
      useVreg = 1'($urandom);
      enter(code, cancel);
      begin
        logic [1:0] st;
        st = cancel ? 2'b00 : expStatus(code);
        checkState("R2-R6 random", st);
        sideChecks("random");
        if (st == 2'b00) continue;
        if (useVreg) begin
          vregWarnIrq = 1; cyc(); vregWarnIrq = 0;
          if (st == 2'b11) checkState("R8 random", 2'b11);
          else begin checkState("R7 random", 2'b00); continue; end
        end
        wakeIrq = 1; cyc(); wakeIrq = 0;
        if (st == 2'b11) begin
          chk("R9 random fast", {4'd0, gates()}, 8'h01);
          cyc();
        end
        checkState("R7 R9 random", 2'b00);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule